// File: doc/BRIEF.md
# Byte-Serial Storage Compare and Move Engine

This block carries out storage-to-storage byte operations over a plain synchronous byte memory port. The caller supplies an operation code, two byte addresses and an 8-bit length-or-immediate field, then pulses `start`. The engine works through the operand fields one byte at a time, starting at the lowest address and moving upward. Each byte is either read and compared, or read, merged and written back. When the work is finished the engine pulses `done`. For compare operations it also leaves a 2-bit condition code.

Six operations are supported:

- compare two character fields;
- compare one byte against an immediate;
- copy a character field;
- store an immediate byte;
- copy only the low nibbles of a field;
- copy only the high nibbles of a field.

The calling sequencer forms both addresses before it starts the engine. The engine adds only the running byte index to them.

Top module: `byteStoreEngine`

## Requirements
- R1: Character forms (opcodes 0, 2, 4, 5) touch `lenField`+1 bytes. A field value of 0 gives 1 byte and 255 gives 256 bytes.
- R2: Byte k of an operand lives at the operand's base address plus k, modulo 2^ADDR_W. The bytes are processed one at a time in increasing k.
- R3: Compares treat bytes as unsigned. They leave `cc` = 0 when the operands are equal, 1 when the first operand is lower and 2 when it is higher. `cc` never shows 3.
- R4: A compare stops at the first unequal byte pair k, and that pair alone sets `cc`. `done` is high in cycle 3(k+1)+1 after the `start` edge. A compare with no mismatch ends in cycle 3·count+1.
- R5: The immediate forms use `lenField` as the immediate byte and touch only the one byte at `addrA`. Opcode 1 compares that byte against the immediate, and `done` falls in cycle 4. Opcode 3 stores the immediate there, and `done` falls in cycle 2.
- R6: Opcode 2 copies byte `addrB`+k to `addrA`+k, reading each byte before writing it. Overlapping fields therefore behave as a forward byte-by-byte copy. `done` falls in cycle 2·count+1.
- R7: Opcode 4 writes the source byte's low nibble into each destination byte and keeps the destination's high nibble. `done` falls in cycle 3·count+1.
- R8: Opcode 5 writes the source byte's high nibble into each destination byte and keeps the destination's low nibble. `done` falls in cycle 3·count+1.
- R9: Compares never write memory. Moves write only first-operand bytes and leave `cc` unchanged.
- R10: After reset, `busy`, `done` and `memEn` are low and `cc` is 0. `done` is a single-cycle pulse, and `busy` stays high from the cycle after `start` up to and including the `done` cycle.
- R11: A `start` seen while `busy` is ignored. Opcodes 6 and 7 perform no memory access, leave `cc` unchanged and raise `done` in cycle 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| opcode | input | 3 | Operation select (see R1–R11) |
| addrA | input | ADDR_W | First operand / destination base address |
| addrB | input | ADDR_W | Second operand / source base address |
| lenField | input | 8 | Encoded length (count−1) or immediate byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| cc | output | 2 | Condition code from the last compare |
| memEn | output | 1 | Memory access strobe |
| memWe | output | 1 | Write when set, read otherwise |
| memAddr | output | ADDR_W | Byte address |
| memWdata | output | 8 | Write data |
| memRdata | input | 8 | Read data, valid the cycle after a read strobe |

## Verification
The bench builds the engine with ADDR_W = 8, so the whole 256-byte address space is modelled. This puts the full 256-byte length and the wrap of a field past the top address within easy reach. Compares are swept over several lengths, with the mismatch placed at every byte position and in both directions. The resulting latency confirms the early stop. Overlapping moves, nibble merges and full-memory comparisons against a bench reference model finish the coverage.

// File: rtl/sbePkg.sv
package sbePkg;
  localparam int LEN_W = 8;

  typedef enum logic [2:0] {
    OP_CMP_CHR = 3'd0,
    OP_CMP_IMM = 3'd1,
    OP_MOV_CHR = 3'd2,
    OP_MOV_IMM = 3'd3,
    OP_MOV_LO  = 3'd4,
    OP_MOV_HI  = 3'd5,
    OP_RSV6    = 3'd6,
    OP_RSV7    = 3'd7
  } opKind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RDA, ST_RDB, ST_EVAL, ST_WR, ST_FIN
  } engState_e;

  typedef struct packed {
    logic latchCmd;
    logic useA;
    logic memEn;
    logic memWe;
    logic capA;
    logic incIdx;
    logic evalCmp;
  } dpStrobe_t;

  function automatic logic isCompare(opKind_e op);
    return (op == OP_CMP_CHR) || (op == OP_CMP_IMM);
  endfunction

  function automatic logic isMove(opKind_e op);
    return (op == OP_MOV_CHR) || (op == OP_MOV_IMM) ||
           (op == OP_MOV_LO) || (op == OP_MOV_HI);
  endfunction

  function automatic logic isCharForm(opKind_e op);
    return (op == OP_CMP_CHR) || (op == OP_MOV_CHR) ||
           (op == OP_MOV_LO) || (op == OP_MOV_HI);
  endfunction
endpackage

// File: rtl/sbeDatapath.sv
module sbeDatapath
  import sbePkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [2:0]        opcode,
  input  logic [ADDR_W-1:0] addrA,
  input  logic [ADDR_W-1:0] addrB,
  input  logic [LEN_W-1:0]  lenField,
  input  logic [7:0]        memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  output logic [1:0]        cc,
  output opKind_e           curOp,
  output logic              lastByte,
  output logic              mismatch
);
  opKind_e           opQ;
  logic [ADDR_W-1:0] baseA, baseB;
  logic [LEN_W-1:0]  lenQ, idx, lastIdx;
  logic [7:0]        regA, opnd2;
  logic [1:0]        ccQ;

  assign lastIdx  = isCharForm(opQ) ? lenQ : '0;
  assign lastByte = (idx == lastIdx);
  assign opnd2    = (opQ == OP_CMP_IMM) ? lenQ : memRdata;
  assign mismatch = (regA != opnd2);
  assign memAddr  = (stb.useA ? baseA : baseB) + ADDR_W'(idx);
  assign curOp    = opQ;
  assign cc       = ccQ;

  always_comb begin
    unique case (opQ)
      OP_MOV_IMM: memWdata = lenQ;
      OP_MOV_LO:  memWdata = {regA[7:4], memRdata[3:0]};
      OP_MOV_HI:  memWdata = {memRdata[7:4], regA[3:0]};
      default:    memWdata = memRdata;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opQ   <= OP_RSV7;
      baseA <= '0;
      baseB <= '0;
      lenQ  <= '0;
      idx   <= '0;
      regA  <= '0;
      ccQ   <= 2'd0;
    end else begin
      if (stb.latchCmd) begin
        opQ   <= opKind_e'(opcode);
        baseA <= addrA;
        baseB <= addrB;
        lenQ  <= lenField;
        idx   <= '0;
        if (isCompare(opKind_e'(opcode))) ccQ <= 2'd0;
      end else begin
        if (stb.incIdx) idx <= idx + 1'b1;
        if (stb.evalCmp && mismatch) ccQ <= (regA < opnd2) ? 2'd1 : 2'd2;
      end
      if (stb.capA) regA <= memRdata;
    end
  end

  AST_CC_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    ccQ != 2'd3); // R3
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    idx <= lastIdx); // R1
  AST_MOVE_KEEPS_CC: assert property (@(posedge clk) disable iff (!rstN)
    (isMove(opQ) && !stb.latchCmd) |=> $stable(ccQ)); // R9
endmodule

// File: rtl/sbeCtrl.sv
module sbeCtrl
  import sbePkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [2:0] opcode,
  input  opKind_e    curOp,
  input  logic       lastByte,
  input  logic       mismatch,
  output dpStrobe_t  stb,
  output logic       busy,
  output logic       done
);
  engState_e state, nextState;

  function automatic engState_e entryState(opKind_e op);
    unique case (op)
      OP_CMP_CHR, OP_CMP_IMM, OP_MOV_LO, OP_MOV_HI: return ST_RDA;
      OP_MOV_CHR: return ST_RDB;
      OP_MOV_IMM: return ST_WR;
      default:    return ST_FIN;
    endcase
  endfunction

  always_comb begin
    stb       = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        stb.latchCmd = start;
        if (start) nextState = entryState(opKind_e'(opcode));
      end
      ST_RDA: begin
        stb.memEn = 1'b1;
        stb.useA  = 1'b1;
        nextState = ST_RDB;
      end
      ST_RDB: begin
        stb.capA  = 1'b1;
        stb.memEn = (curOp != OP_CMP_IMM);
        nextState = isCompare(curOp) ? ST_EVAL : ST_WR;
      end
      ST_EVAL: begin
        stb.evalCmp = 1'b1;
        if (mismatch || lastByte) nextState = ST_FIN;
        else begin
          stb.incIdx = 1'b1;
          nextState  = ST_RDA;
        end
      end
      ST_WR: begin
        stb.memEn = 1'b1;
        stb.memWe = 1'b1;
        stb.useA  = 1'b1;
        if (lastByte) nextState = ST_FIN;
        else begin
          stb.incIdx = 1'b1;
          nextState  = (curOp == OP_MOV_CHR) ? ST_RDB : ST_RDA;
        end
      end
      ST_FIN:  nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FIN);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10
  AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !stb.memEn); // R11
  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    stb.memWe |-> isMove(curOp)); // R9
  AST_WRITE_TO_DEST: assert property (@(posedge clk) disable iff (!rstN)
    stb.memWe |-> stb.useA); // R9
endmodule

// File: rtl/byteStoreEngine.sv
module byteStoreEngine
  import sbePkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [2:0]        opcode,
  input  logic [ADDR_W-1:0] addrA,
  input  logic [ADDR_W-1:0] addrB,
  input  logic [7:0]        lenField,
  output logic              busy,
  output logic              done,
  output logic [1:0]        cc,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  input  logic [7:0]        memRdata
);
  dpStrobe_t stb;
  opKind_e   curOp;
  logic      lastByte, mismatch;

  sbeCtrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode),
    .curOp(curOp), .lastByte(lastByte), .mismatch(mismatch),
    .stb(stb), .busy(busy), .done(done)
  );

  sbeDatapath #(.ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .opcode(opcode),
    .addrA(addrA), .addrB(addrB), .lenField(lenField),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .cc(cc), .curOp(curOp), .lastByte(lastByte), .mismatch(mismatch)
  );

  assign memEn = stb.memEn;
  assign memWe = stb.memWe;
endmodule

// File: tb/tb_byteStoreEngine.sv
module tb_byteStoreEngine;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [2:0] opcode = '0;
  logic [AW-1:0] addrA = '0, addrB = '0;
  logic [7:0] lenField = '0;
  logic busy, done, memEn, memWe;
  logic [1:0] cc;
  logic [AW-1:0] memAddr;
  logic [7:0] memWdata;
  logic [7:0] memRdata = '0;

  logic [7:0] mem [256];
  logic [7:0] refMem [256];
  logic [1:0] refCc = 2'd0;
  int nChecks = 0;
  int nFails = 0;

  always #2.5 clk = ~clk;

  byteStoreEngine #(.ADDR_W(AW)) dut (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode),
    .addrA(addrA), .addrB(addrB), .lenField(lenField),
    .busy(busy), .done(done), .cc(cc), .memEn(memEn), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata)
  );

  always @(posedge clk) begin
    if (memEn) begin
      if (memWe) mem[memAddr] <= memWdata;
      else       memRdata <= mem[memAddr];
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic checkMem(input string tag);
    int bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== refMem[i]) bad++;
    check(tag, bad, 0);
  endtask

  task automatic setByte(input int a, input logic [7:0] v);
    mem[a[7:0]] = v;
    refMem[a[7:0]] = v;
  endtask

  // reference model derived from the requirements; returns expected latency
  function automatic int model(input int op, input logic [7:0] a,
                               input logic [7:0] b, input logic [7:0] len);
    int n = len + 1;
    logic [7:0] x, y;
    case (op)
      0: begin
        refCc = 2'd0;
        for (int k = 0; k < n; k++) begin
          x = refMem[a + 8'(k)]; y = refMem[b + 8'(k)];
          if (x != y) begin refCc = (x < y) ? 2'd1 : 2'd2; return 3*(k+1)+1; end
        end
        return 3*n+1;
      end
      1: begin
        x = refMem[a];
        refCc = (x == len) ? 2'd0 : ((x < len) ? 2'd1 : 2'd2);
        return 4;
      end
      2: begin
        for (int k = 0; k < n; k++) refMem[a + 8'(k)] = refMem[b + 8'(k)];
        return 2*n+1;
      end
      3: begin refMem[a] = len; return 2; end
      4: begin
        for (int k = 0; k < n; k++)
          refMem[a + 8'(k)] = {refMem[a + 8'(k)][7:4], refMem[b + 8'(k)][3:0]};
        return 3*n+1;
      end
      5: begin
        for (int k = 0; k < n; k++)
          refMem[a + 8'(k)] = {refMem[b + 8'(k)][7:4], refMem[a + 8'(k)][3:0]};
        return 3*n+1;
      end
      default: return 1;
    endcase
  endfunction

  // run one operation; pokeAt>0 pulses a stray start in that cycle
  task automatic runOp(input string tag, input int op, input int a, input int b,
                       input int len, input int pokeAt);
    int lat = 0;
    int expLat;
    logic sawIdleBusy = 1'b0;
    expLat = model(op, a[7:0], b[7:0], len[7:0]);
    @(negedge clk);
    opcode = op[2:0]; addrA = a[7:0]; addrB = b[7:0]; lenField = len[7:0];
    start = 1'b1;
    forever begin
      @(negedge clk);
      start = 1'b0;
      lat++;
      if (!busy) sawIdleBusy = 1'b1;
      if (done) break;
      if (lat == pokeAt) begin
        start = 1'b1; opcode = 3'd3; addrA = 8'd0; lenField = 8'hEE;
      end
      if (lat > 2000) begin
        check({tag, " hang"}, lat, expLat);
        break;
      end
    end
    check({tag, " latency R10"}, lat, expLat);
    check({tag, " busy R10"}, int'(sawIdleBusy), 0);
    check({tag, " cc R3"}, int'(cc), int'(refCc));
    checkMem({tag, " memory R9"});
    @(negedge clk);
    check({tag, " done pulse R10"}, int'(done), 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) setByte(i, 8'(i*37 + 11));
    repeat (3) @(negedge clk);
    check("reset busy R10", int'(busy), 0);
    check("reset done R10", int'(done), 0);
    check("reset cc R10", int'(cc), 0);
    check("reset memEn R10", int'(memEn), 0);
    rstN = 1'b1;

    // R3 R4: compares with mismatch at each position, both directions
    foreach (mem[i]) ;
    for (int len = 0; len < 8; len++) begin
      for (int k = 0; k <= len + 1; k++) begin
        for (int dir = 0; dir < 2; dir++) begin
          for (int j = 0; j <= len; j++) setByte(64 + j, refMem[16 + j]);
          if (k <= len) setByte(64 + k, dir ? refMem[16 + k] + 8'd1 : refMem[16 + k] - 8'd1);
          runOp("cmp sweep R4", 0, 16, 64, len, 0);
        end
      end
    end
    // R3 unsigned: 0x80 vs 0x7F
    setByte(200, 8'h80); setByte(210, 8'h7F);
    runOp("cmp unsigned R3", 0, 200, 210, 0, 0);
    check("cmp unsigned high R3", int'(cc), 2);
    // R1: full 256-byte equal compare
    runOp("cmp 256 R1", 0, 5, 5, 255, 0);
    check("cmp 256 cc R1", int'(cc), 0);
    // R5 immediate compare
    setByte(33, 8'h50);
    runOp("cmpi eq R5", 1, 33, 0, 8'h50, 0);
    runOp("cmpi low R5", 1, 33, 0, 8'h90, 0);
    runOp("cmpi high R5", 1, 33, 0, 8'h10, 0);
    // R9: moves keep cc (cc is 2 from previous)
    runOp("movi R5", 3, 34, 0, 8'hA5, 0);
    check("move keeps cc R9", int'(cc), 2);
    // R6 moves: plain, overlapping forward, full length
    runOp("movc R6", 2, 100, 40, 5, 0);
    runOp("movc overlap R6", 2, 121, 120, 9, 0);
    runOp("movc 256 R1", 2, 7, 3, 255, 0);
    // R2 wrap past top address
    runOp("movc wrap R2", 2, 250, 90, 20, 0);
    // R7 R8 nibble moves over several lengths
    for (int len = 0; len < 6; len++) begin
      runOp("movlo R7", 4, 140 + len*3, 20 + len, len, 0);
      runOp("movhi R8", 5, 180 + len*3, 60 + len, len, 0);
    end
    runOp("movhi wrap R8", 5, 252, 10, 9, 0);
    // R11: stray start while busy, and reserved opcodes
    runOp("busy start R11", 0, 16, 16, 10, 3);
    runOp("busy start move R11", 2, 60, 61, 4, 5);
    runOp("rsv6 R11", 6, 1, 2, 3, 0);
    runOp("rsv7 R11", 7, 1, 2, 3, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule